// File: doc/BRIEF.md
# Chained Grayscale PWM Driver Controller

This block drives a serial chain of 16-channel, 12-bit grayscale PWM driver devices. It generates the grayscale counting clock, a blanking strobe, a latch strobe, and a serial clock with data line. The serial data changes while the serial clock is low and is sampled by the chain on the rising edge. A host write port takes a channel index and a 12-bit level and places the level in a working copy of the frame.

Each grayscale cycle is a fixed number of grayscale clock pulses. After the last pulse the controller blanks the outputs. If the working copy has changed, it is promoted to the live copy, and the live copy is then shifted out highest channel first. A frame is latched into the chain only after it has been shifted out in full. The mode input selects when shifting happens:
- Mode 0 shifts the frame during the next PWM cycle and latches it at the blank that follows.
- Mode 1 holds blanking for the whole shift, then latches and releases blanking.

An enable input turns all outputs dark while it is low. Raising it again forces a refresh of the chain. After reset the controller clears the chain with a run of zero bits and one latch pulse.

Top module: `dcpwm_ctrl`

## Requirements
- R1: A write whose index is at or above 16 × N_DEV (the channel count) changes no stored level and starts no frame transfer.
- R2: A frame is 192 × N_DEV bits, one bit per serial clock. It goes out from the highest channel down to channel 0, each level MSB first. The data line holds its value for as long as the serial clock is high and changes only as the clock falls.
- R3: Each PWM cycle contains exactly GS_CNT grayscale clock pulses between the fall of blanking and its next rise.
- R4: The grayscale clock is low for at least one cycle before blanking rises. The latch is high only while blanking is high. Blanking falls no earlier than one cycle after the latch goes low.
- R5: The latch pulse lasts one cycle and happens only after a complete new frame has been shifted since the previous blank. A blank with no pending change shifts and latches nothing.
- R6: A write made while a frame is being shifted does not alter that frame. It appears in the next frame.
- R7: In mode 0 (mode_i=0) the frame is shifted while blanking is low and latched at the following blank. In mode 1 (mode_i=1) the whole frame is shifted while blanking is high, then the latch pulses and blanking falls within three cycles.
- R8: While en_i is low, blanking stays high and the grayscale clock stays low. A rising en_i forces a frame carrying the current levels to be shifted and latched.
- R9: After reset, blanking is high and the latch is low. The controller then shifts 200 × N_DEV zero bits and pulses the latch once.
- R10: Channels not written keep their previous level in every later frame. Writes to different channels across several blanks accumulate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Global output enable |
| mode_i | input | 1 | 0: shift during PWM cycle, 1: shift inside blanking |
| wr_i | input | 1 | Level write strobe |
| wr_idx_i | input | IDX_W | Channel index of the write |
| wr_lvl_i | input | LVL_W | Grayscale level of the write |
| gsclk_o | output | 1 | Grayscale counting clock |
| blank_o | output | 1 | Blanking strobe, high turns outputs off |
| latch_o | output | 1 | Latch strobe to the chain |
| sclk_o | output | 1 | Serial clock |
| sdata_o | output | 1 | Serial data, highest channel first |

## Verification
The latency of a write depends on the mode. In mode 0 a write reaches the chain at the second blank after it: the first blank promotes it and the second latches it. In mode 1 it is latched at the first blank, roughly 2 × SCK_DIV × frame-bits cycles after blanking rises. Blanking falls two cycles after the latch goes high, and the grayscale clock drops one cycle before blanking rises.

The bench does not count fixed cycle offsets. It waits on latch and blanking-edge events, with timeouts, and compares the bits captured on each serial-clock rise against a frame built from its own level table. Inputs are driven on the falling clock edge and outputs are sampled on the rising edge, before the design's registers update.

// File: rtl/dcpwm_pkg.sv
package dcpwm_pkg;
  typedef enum logic [2:0] {
    ST_INIT,
    ST_RUN,
    ST_GAP,
    ST_BLANK,
    ST_SHIFT,
    ST_LATCH,
    ST_HOLD
  } seq_state_e;
endpackage

// File: rtl/dcpwm_frame_buf.sv
module dcpwm_frame_buf #(
  parameter int NCH   = 64,
  parameter int LVL_W = 12,
  parameter int IDX_W = 7,
  localparam int CW   = $clog2(NCH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [LVL_W-1:0] wr_lvl_i,
  input  logic             swap_i,
  input  logic [CW-1:0]    rd_idx_i,
  output logic             dirty_o,
  output logic [LVL_W-1:0] rd_lvl_o
);
  logic [LVL_W-1:0] work_q [NCH];
  logic [LVL_W-1:0] live_q [NCH];
  logic             dirty_q;
  logic             wr_ok;

  assign wr_ok = wr_i && (wr_idx_i < IDX_W'(NCH));

  // promotion copies work into live; live stays untouched by writes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NCH; i++) begin
        work_q[i] <= '0;
        live_q[i] <= '0;
      end
      dirty_q <= 1'b0;
    end else begin
      if (swap_i) begin
        for (int i = 0; i < NCH; i++) live_q[i] <= work_q[i];
      end
      if (wr_ok) work_q[wr_idx_i[CW-1:0]] <= wr_lvl_i;
      if (wr_ok)       dirty_q <= 1'b1;
      else if (swap_i) dirty_q <= 1'b0;
    end
  end

  assign dirty_o  = dirty_q;
  assign rd_lvl_o = live_q[rd_idx_i];
endmodule

// File: rtl/dcpwm_shifter.sv
module dcpwm_shifter #(
  parameter int NCH     = 64,
  parameter int LVL_W   = 12,
  parameter int SCK_DIV = 2,
  parameter int CNT_W   = 10,
  localparam int CW     = $clog2(NCH),
  localparam int BW     = $clog2(LVL_W),
  localparam int DIV_W  = $clog2(SCK_DIV + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             clear_i,
  input  logic [CNT_W-1:0] nbits_i,
  input  logic [LVL_W-1:0] ch_lvl_i,
  output logic [CW-1:0]    ch_idx_o,
  output logic             sclk_o,
  output logic             sdata_o,
  output logic             busy_o,
  output logic             done_o
);
  logic             busy_q, zero_q, sclk_q, done_q;
  logic [DIV_W-1:0] div_q;
  logic [CW-1:0]    ch_q;
  logic [BW-1:0]    bit_q;
  logic [CNT_W-1:0] left_q;
  logic             tick;

  assign tick = (div_q == DIV_W'(SCK_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      zero_q <= 1'b0;
      sclk_q <= 1'b0;
      done_q <= 1'b0;
      div_q  <= '0;
      ch_q   <= '0;
      bit_q  <= '0;
      left_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !busy_q) begin
        busy_q <= 1'b1;
        zero_q <= clear_i;
        sclk_q <= 1'b0;
        div_q  <= '0;
        ch_q   <= CW'(NCH - 1);
        bit_q  <= BW'(LVL_W - 1);
        left_q <= nbits_i - 1'b1;
      end else if (busy_q) begin
        div_q <= tick ? '0 : div_q + 1'b1;
        if (tick) begin
          if (!sclk_q) begin
            sclk_q <= 1'b1;
          end else begin
            // falling edge: advance to the next bit
            sclk_q <= 1'b0;
            if (left_q == '0) begin
              busy_q <= 1'b0;
              done_q <= 1'b1;
            end else begin
              left_q <= left_q - 1'b1;
              if (bit_q == '0) begin
                bit_q <= BW'(LVL_W - 1);
                ch_q  <= (ch_q == '0) ? CW'(NCH - 1) : ch_q - 1'b1;
              end else begin
                bit_q <= bit_q - 1'b1;
              end
            end
          end
        end
      end
    end
  end

  assign ch_idx_o = ch_q;
  assign sclk_o   = sclk_q;
  assign sdata_o  = busy_q && !zero_q && ch_lvl_i[bit_q];
  assign busy_o   = busy_q;
  assign done_o   = done_q;
endmodule

// File: rtl/dcpwm_ctrl.sv
module dcpwm_ctrl
  import dcpwm_pkg::*;
#(
  parameter int N_DEV       = 4,
  parameter int CH_PER_DEV  = 16,
  parameter int LVL_W       = 12,
  parameter int GS_CNT      = 4096,
  parameter int GS_HALF     = 2,
  parameter int SCK_DIV     = 2,
  parameter int CLR_PER_DEV = 200,
  localparam int NCH        = N_DEV * CH_PER_DEV,
  localparam int IDX_W      = $clog2(NCH) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             mode_i,
  input  logic             wr_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [LVL_W-1:0] wr_lvl_i,
  output logic             gsclk_o,
  output logic             blank_o,
  output logic             latch_o,
  output logic             sclk_o,
  output logic             sdata_o
);
  localparam int CW         = $clog2(NCH);
  localparam int FRAME_BITS = NCH * LVL_W;
  localparam int CLR_BITS   = N_DEV * CLR_PER_DEV;
  localparam int MAX_BITS   = (CLR_BITS > FRAME_BITS) ? CLR_BITS : FRAME_BITS;
  localparam int CNT_W      = $clog2(MAX_BITS + 1);
  localparam int PH_W       = $clog2(2 * GS_HALF);
  localparam int GS_W       = $clog2(GS_CNT);

  seq_state_e       st_q, st_d;
  logic [PH_W-1:0]  ph_q;
  logic [GS_W-1:0]  gcnt_q;
  logic             init_go_q, need_lat_q, pend_q, force_q, en_q;
  logic             gsclk_q, blank_q, latch_q;
  logic             sh_start, sh_clear, sh_busy, sh_done, swap, dirty;
  logic [CW-1:0]    ch_idx;
  logic [LVL_W-1:0] ch_lvl;
  logic [CNT_W-1:0] sh_nbits;
  logic             ph_last, run_end, refresh;

  assign ph_last  = (ph_q == PH_W'(2 * GS_HALF - 1));
  assign run_end  = (st_q == ST_RUN) && ph_last && (gcnt_q == GS_W'(GS_CNT - 1));
  assign refresh  = (dirty || force_q) && !sh_busy;
  assign sh_nbits = sh_clear ? CNT_W'(CLR_BITS) : CNT_W'(FRAME_BITS);

  dcpwm_frame_buf #(.NCH(NCH), .LVL_W(LVL_W), .IDX_W(IDX_W)) u_buf (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr_i),
    .wr_idx_i (wr_idx_i),
    .wr_lvl_i (wr_lvl_i),
    .swap_i   (swap),
    .rd_idx_i (ch_idx),
    .dirty_o  (dirty),
    .rd_lvl_o (ch_lvl)
  );

  dcpwm_shifter #(.NCH(NCH), .LVL_W(LVL_W), .SCK_DIV(SCK_DIV), .CNT_W(CNT_W)) u_sh (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (sh_start),
    .clear_i  (sh_clear),
    .nbits_i  (sh_nbits),
    .ch_lvl_i (ch_lvl),
    .ch_idx_o (ch_idx),
    .sclk_o   (sclk_o),
    .sdata_o  (sdata_o),
    .busy_o   (sh_busy),
    .done_o   (sh_done)
  );

  always_comb begin
    st_d     = st_q;
    sh_start = 1'b0;
    sh_clear = 1'b0;
    swap     = 1'b0;
    case (st_q)
      ST_INIT: begin
        sh_start = !init_go_q;
        sh_clear = !init_go_q;
        if (init_go_q && sh_done) st_d = ST_LATCH;
      end
      ST_RUN:   if (run_end) st_d = ST_GAP;
      ST_GAP:   st_d = ST_BLANK;
      ST_BLANK: begin
        if (refresh) begin
          swap = dirty;
          if (mode_i) begin
            sh_start = 1'b1;
            st_d     = ST_SHIFT;
          end else begin
            st_d = need_lat_q ? ST_LATCH : ST_HOLD;
          end
        end else begin
          st_d = (need_lat_q && !sh_busy) ? ST_LATCH : ST_HOLD;
        end
      end
      ST_SHIFT: if (sh_done) st_d = ST_LATCH;
      ST_LATCH: st_d = ST_HOLD;
      ST_HOLD: begin
        sh_start = pend_q;
        st_d     = ST_RUN;
      end
      default:  st_d = ST_INIT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_INIT;
      ph_q       <= '0;
      gcnt_q     <= '0;
      init_go_q  <= 1'b0;
      need_lat_q <= 1'b0;
      pend_q     <= 1'b0;
      force_q    <= 1'b0;
      en_q       <= 1'b1;
      gsclk_q    <= 1'b0;
      blank_q    <= 1'b1;
      latch_q    <= 1'b0;
    end else begin
      st_q <= st_d;
      en_q <= en_i;
      if (en_i && !en_q)                         force_q <= 1'b1;
      else if (st_q == ST_BLANK && refresh)      force_q <= 1'b0;
      if (st_q == ST_RUN) begin
        ph_q <= ph_last ? '0 : ph_q + 1'b1;
        if (ph_last) gcnt_q <= run_end ? '0 : gcnt_q + 1'b1;
      end else begin
        ph_q   <= '0;
        gcnt_q <= '0;
      end
      if (sh_start && sh_clear) init_go_q <= 1'b1;
      if (st_q == ST_LATCH)                     need_lat_q <= 1'b0;
      else if (sh_done && st_q != ST_INIT)      need_lat_q <= 1'b1;
      if (st_q == ST_BLANK && refresh && !mode_i) pend_q <= 1'b1;
      else if (st_q == ST_HOLD)                   pend_q <= 1'b0;
      // en_i gates the clock one cycle ahead of blanking (gap rule)
      gsclk_q <= (st_q == ST_RUN) && (ph_q >= PH_W'(GS_HALF)) && en_i;
      blank_q <= !(st_q == ST_RUN || st_q == ST_GAP) || !en_q;
      latch_q <= (st_q == ST_LATCH);
    end
  end

  assign gsclk_o = gsclk_q;
  assign blank_o = blank_q;
  assign latch_o = latch_q;
endmodule

// File: rtl/dcpwm_ctrl_chk.sv
module dcpwm_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic gsclk_o,
  input logic blank_o,
  input logic latch_o,
  input logic sclk_o,
  input logic sdata_o
);
  p_gs_low_before_blank_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(blank_o) |-> !$past(gsclk_o));

  p_latch_inside_blank_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_o |-> blank_o);

  p_latch_before_unblank_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(blank_o) |-> !$past(latch_o));

  p_latch_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_o |=> !latch_o);

  p_sdata_held_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> $stable(sdata_o));

  p_dark_gs_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !gsclk_o);

  p_dark_blank_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !$past(en_i)) |=> blank_o);
endmodule

bind dcpwm_ctrl dcpwm_ctrl_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .en_i    (en_i),
  .gsclk_o (gsclk_o),
  .blank_o (blank_o),
  .latch_o (latch_o),
  .sclk_o  (sclk_o),
  .sdata_o (sdata_o)
);

// File: tb/sim_dcpwm_ctrl.sv
`timescale 1ns/1ps
module sim_dcpwm_ctrl;
  localparam int GS  = 128;
  localparam int NCH = 16;
  localparam int FB  = 192;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b1, mode = 1'b0, wr = 1'b0;
  logic [4:0]  widx = '0;
  logic [11:0] wlvl = '0;
  logic gsclk, blank, latch, sclk, sdata;

  always #2 clk = ~clk;

  dcpwm_ctrl #(.N_DEV(1), .GS_CNT(GS), .GS_HALF(2), .SCK_DIV(1)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .mode_i(mode), .wr_i(wr),
    .wr_idx_i(widx), .wr_lvl_i(wlvl), .gsclk_o(gsclk), .blank_o(blank),
    .latch_o(latch), .sclk_o(sclk), .sdata_o(sdata)
  );

  int checks = 0, fails = 0;
  bit done_flag = 0;
  logic [11:0] exp_lvl [NCH];

  // monitor state
  logic [FB-1:0] cap = '0, lat_frame = '0;
  int bits = 0, ones = 0, lowbits = 0;
  int lat_cnt = 0, lat_bits = 0, lat_ones = 0, lat_low = 0;
  int gs_run = 0, last_gs = 0, blank_rises = 0;
  int viol_r2 = 0, viol_r4 = 0;
  logic sclk_p = 0, blank_p = 1, gs_p = 0, lat_p = 0, sd_p = 0;

  always @(posedge clk) begin
    if (rst_n) begin
      if (sclk && !sclk_p) begin
        cap = {cap[FB-2:0], sdata};
        bits++;
        ones += int'(sdata);
        if (!blank) lowbits++;
      end
      if (sclk && sclk_p && sdata != sd_p) viol_r2++;
      if (latch && !blank) viol_r4++;
      if (latch) begin
        lat_cnt++; lat_bits = bits; lat_frame = cap; lat_ones = ones; lat_low = lowbits;
        bits = 0; ones = 0; lowbits = 0;
      end
      if (gsclk && !gs_p) gs_run++;
      if (blank && !blank_p) begin
        last_gs = gs_run; gs_run = 0; blank_rises++;
        if (gs_p) viol_r4++;
      end
      if (!blank && blank_p && lat_p) viol_r4++;
    end
    sclk_p = sclk; blank_p = blank; gs_p = gsclk; lat_p = latch; sd_p = sdata;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic [FB-1:0] exp_frame();
    logic [FB-1:0] f;
    for (int c = 0; c < NCH; c++) f[c*12 +: 12] = exp_lvl[c];
    return f;
  endfunction

  task automatic do_write(input int idx, input logic [11:0] v);
    @(negedge clk);
    wr = 1'b1; widx = 5'(idx); wlvl = v;
    @(negedge clk);
    wr = 1'b0;
    if (idx < NCH) exp_lvl[idx] = v;
  endtask

  task automatic wait_latch(input string req);
    int start = lat_cnt;
    int t = 0;
    while (lat_cnt == start && t < 6000) begin @(negedge clk); t++; end
    check(lat_cnt != start, req, lat_cnt, start + 1);
  endtask

  task automatic wait_blanks(input int n);
    int target = blank_rises + n;
    int t = 0;
    while (blank_rises < target && t < 8000) begin @(negedge clk); t++; end
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    check(blank === 1'b1, "R9 blank in reset", blank, 1);
    check(latch === 1'b0, "R9 latch in reset", latch, 0);
    rst_n = 1'b1;
    wait_latch("R9 clear latch");
    check(lat_bits == 200, "R9 clear bit count", lat_bits, 200);
    check(lat_ones == 0, "R9 clear bits zero", lat_ones, 0);
  endtask

  task automatic t_gs_count;
    wait_blanks(2);
    check(last_gs == GS, "R3 pulses per cycle", last_gs, GS);
  endtask

  task automatic t_mode0;
    do_write(0, 12'hABC);
    do_write(15, 12'h123);
    do_write(7, 12'h5A5);
    wait_latch("R7 mode0 latch");
    check(lat_frame == exp_frame(), "R2 frame order", lat_frame[63:0], exp_frame() & 64'hFFFFFFFFFFFFFFFF);
    check(lat_bits == FB, "R2 frame length", lat_bits, FB);
    check(lat_low == FB, "R7 mode0 shifts unblanked", lat_low, FB);
  endtask

  task automatic t_keep;
    do_write(1, 12'h001);
    wait_latch("R10 latch");
    check(lat_frame == exp_frame(), "R10 levels kept", lat_frame[191:128], exp_frame() >> 128);
  endtask

  task automatic t_ignore;
    int c0;
    wait_blanks(1);
    c0 = lat_cnt;
    do_write(16, 12'hFFF);
    do_write(31, 12'hEEE);
    wait_blanks(3);
    check(lat_cnt == c0, "R5 no latch without change", lat_cnt, c0);
    check(bits == 0, "R1 ignored write shifts nothing", bits, 0);
    do_write(2, 12'h222);
    wait_latch("R1 latch");
    check(lat_frame == exp_frame(), "R1 frame untouched", lat_frame[63:0], exp_frame() & 64'hFFFFFFFFFFFFFFFF);
  endtask

  task automatic t_mode1;
    logic [FB-1:0] fa;
    int t = 0;
    wait_blanks(1);
    @(negedge clk); mode = 1'b1;
    do_write(3, 12'h777);
    wait_latch("R7 mode1 latch");
    check(lat_low == 0, "R7 mode1 shifts in blank", lat_low, 0);
    check(lat_frame == exp_frame(), "R7 mode1 frame", lat_frame[63:0], exp_frame() & 64'hFFFFFFFFFFFFFFFF);
    while (blank && t < 10) begin @(negedge clk); t++; end
    check(t <= 3, "R7 blank release after latch", t, 3);
    // R6: write arriving mid-shift belongs to the next frame
    do_write(4, 12'h444);
    wait_blanks(1);
    repeat (5) @(negedge clk);
    fa = exp_frame();
    do_write(5, 12'h555);
    wait_latch("R6 first latch");
    check(lat_frame == fa, "R6 frame unchanged by late write", lat_frame[71:0], fa[71:0]);
    wait_latch("R6 second latch");
    check(lat_frame == exp_frame(), "R6 late write in next frame", lat_frame[71:0], exp_frame() & 72'hFFFFFFFFFFFFFFFFFF);
  endtask

  task automatic t_enable;
    int bad = 0;
    wait_blanks(1);
    @(negedge clk); mode = 1'b0;
    wait_blanks(1);
    @(negedge clk); en = 1'b0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 1200; i++) begin
      @(negedge clk);
      if (!blank || gsclk) bad++;
    end
    check(bad == 0, "R8 dark while disabled", bad, 0);
    @(negedge clk); en = 1'b1;
    wait_latch("R8 refresh latch");
    check(lat_frame == exp_frame(), "R8 refresh frame", lat_frame[63:0], exp_frame() & 64'hFFFFFFFFFFFFFFFF);
    check(lat_bits == FB, "R8 refresh length", lat_bits, FB);
  endtask

  task automatic finish_run;
    if (!done_flag) begin
      done_flag = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    for (int c = 0; c < NCH; c++) exp_lvl[c] = '0;
    t_reset();
    t_gs_count();
    t_mode0();
    t_keep();
    t_ignore();
    t_mode1();
    t_enable();
    check(viol_r4 == 0, "R4 strobe ordering", viol_r4, 0);
    check(viol_r2 == 0, "R2 data held while sclk high", viol_r2, 0);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end
endmodule